// File: doc/BRIEF.md
# Serial Clock-Output Freeze Controller

This block holds a twelve-bit mask that decides, for each of twelve clock outputs, whether the clock passes through or is held low. The mask is written over a one-wire serial line. The line is sampled on the rising edge of a serial clock. The line rests high. A low bit marks the start of a frame, and exactly twelve data bits follow it, one per serial clock period. When the twelfth bit arrives, the whole new mask replaces the active one in a single step. A partly received frame therefore never reaches the outputs.

Each output has its own clock. The active mask bit for an output passes through a two-flop synchronizer clocked by that output's clock. It is then taken up on a falling edge of that clock, so the gate only opens or closes while the clock is low. A frozen output is held low. An enabled output follows its clock with every high phase whole.

Top module: `clk_freeze_ctl`

## Requirements
- R1: While no frame is in progress, a high level on `sdin` at a rising `sclk` edge changes neither `mask_q` nor any output.
- R2: A low level on `sdin` at a rising `sclk` edge, when no frame is in progress, is a start bit. The next twelve rising edges each sample one data bit, whatever its value.
- R3: Data bit k of a frame (k = 0 first, through 11) lands in `mask_q[k]`, and `mask_q[k]` controls `gated_clk[k]`. Outputs 0 to 3 form group A, 4 to 7 group B and 8 to 11 group C.
- R4: A mask bit of 1 makes `gated_clk[k]` follow `out_clk[k]`. A mask bit of 0 holds `gated_clk[k]` at 0. Either state takes effect within four `out_clk[k]` periods of the `mask_q` change.
- R5: `mask_q` keeps its old value through the edge that samples the twelfth data bit. It takes the new frame value at the next rising `sclk` edge.
- R6: A new start bit may be sampled on the rising edge right after the twelfth data bit (back-to-back frames). Each frame is committed in turn.
- R7: Synchronous active-high `rst` sets all twelve `mask_q` bits to 1, enables every output and abandons any frame in progress.
- R8: Every high pulse on `gated_clk[k]` lasts exactly one full high phase of `out_clk[k]`. Freezing or enabling never produces a shortened pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial bit clock; the receiver and mask register run on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sdin | input | 1 | Serial frame line; rests high |
| out_clk | input | 12 | One clock per output; bit k is the clock of output k |
| gated_clk | output | 12 | Gated clock outputs |
| mask_q | output | 12 | Active freeze mask (1 = enabled) |

## Verification
A fixed set of mask patterns is loaded one after another: all frozen, all enabled, alternating bits in both phases, a single bit at each end, and whole groups on or off. These show apart a reversed bit order, a shifted bit index, an inverted polarity and a mix-up between clock groups. Directed cases then cover a long idle stretch, frames sent with no gap between them, a reset in the middle of a frame, and the cycle in which the commit takes place. A pulse-width monitor on every output watches all mask changes for runt pulses.

// File: rtl/fz_pkg.sv
`timescale 1ns/1ps
package fz_pkg;
    localparam int NUM_OUT  = 12;
    localparam int IDX_W    = $clog2(NUM_OUT);
    localparam int SYNC_LEN = 2;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_DATA = 1'b1
    } rx_state_e;

    typedef struct packed {
        rx_state_e          st;
        logic [IDX_W-1:0]   idx;
    } rx_ctl_t;

    function automatic logic [IDX_W-1:0] last_idx();
        return IDX_W'(NUM_OUT - 1);
    endfunction
endpackage

// File: rtl/fz_serial_rx.sv
`timescale 1ns/1ps
module fz_serial_rx
    import fz_pkg::*;
(
    input  logic               sclk,
    input  logic               rst,
    input  logic               sdin,
    output logic               commit,
    output logic [NUM_OUT-1:0] frame_bits
);
    rx_ctl_t            ctl;
    logic [NUM_OUT-1:0] shadow;

    always_ff @(posedge sclk) begin
        if (rst) begin
            ctl    <= '{st: RX_IDLE, idx: '0};
            shadow <= '1;
            commit <= 1'b0;
        end else begin
            commit <= 1'b0;
            unique case (ctl.st)
                RX_IDLE: begin
                    if (!sdin) begin
                        ctl <= '{st: RX_DATA, idx: '0};
                    end
                end
                RX_DATA: begin
                    shadow[ctl.idx] <= sdin;
                    if (ctl.idx == last_idx()) begin
                        commit <= 1'b1;
                        ctl.st <= RX_IDLE;
                    end else begin
                        ctl.idx <= ctl.idx + 1'b1;
                    end
                end
                default: ctl.st <= RX_IDLE;
            endcase
        end
    end

    assign frame_bits = shadow;

    // R1
    idle_hold_chk: assert property (@(posedge sclk) disable iff (rst)
        (ctl.st == RX_IDLE && sdin) |=> (ctl.st == RX_IDLE && !commit));

    // R2
    start_detect_chk: assert property (@(posedge sclk) disable iff (rst)
        (ctl.st == RX_IDLE && !sdin) |=> (ctl.st == RX_DATA && ctl.idx == '0));

    // R2
    idx_bound_chk: assert property (@(posedge sclk) disable iff (rst)
        (ctl.st == RX_DATA) |-> (ctl.idx <= last_idx()));

    // R6
    frame_end_chk: assert property (@(posedge sclk) disable iff (rst)
        (ctl.st == RX_DATA && ctl.idx == last_idx()) |=> (commit && ctl.st == RX_IDLE));
endmodule

// File: rtl/fz_mask_hold.sv
`timescale 1ns/1ps
module fz_mask_hold
    import fz_pkg::*;
(
    input  logic               sclk,
    input  logic               rst,
    input  logic               commit,
    input  logic [NUM_OUT-1:0] frame_bits,
    output logic [NUM_OUT-1:0] mask
);
    logic rst_d;

    always_ff @(posedge sclk) begin
        if (rst) begin
            mask <= '1;
        end else if (commit) begin
            mask <= frame_bits;
        end
    end

    always_ff @(posedge sclk) rst_d <= rst;

    // R7
    always @(posedge sclk) begin
        if (rst_d === 1'b1 && rst === 1'b0) begin
            mask_reset_chk: assert (mask == '1);
        end
    end

    // R5
    mask_quiet_chk: assert property (@(posedge sclk) disable iff (rst)
        !commit |=> $stable(mask));
endmodule

// File: rtl/fz_gate_cell.sv
`timescale 1ns/1ps
module fz_gate_cell
    import fz_pkg::*;
(
    input  logic clk_in,
    input  logic rst,
    input  logic en_async,
    output logic clk_out
);
    logic [SYNC_LEN-1:0] sync_q;
    logic                en_lo;

    always_ff @(posedge clk_in) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_LEN-2:0], en_async};
        end
    end

    always_ff @(negedge clk_in) begin
        if (rst) begin
            en_lo <= 1'b1;
        end else begin
            en_lo <= sync_q[SYNC_LEN-1];
        end
    end

    always_comb clk_out = clk_in & en_lo;
endmodule

// File: rtl/clk_freeze_ctl.sv
`timescale 1ns/1ps
module clk_freeze_ctl
    import fz_pkg::*;
(
    input  logic               sclk,
    input  logic               rst,
    input  logic               sdin,
    input  logic [NUM_OUT-1:0] out_clk,
    output logic [NUM_OUT-1:0] gated_clk,
    output logic [NUM_OUT-1:0] mask_q
);
    logic               commit;
    logic [NUM_OUT-1:0] frame_bits;

    fz_serial_rx rx_i (
        .sclk       (sclk),
        .rst        (rst),
        .sdin       (sdin),
        .commit     (commit),
        .frame_bits (frame_bits)
    );

    fz_mask_hold hold_i (
        .sclk       (sclk),
        .rst        (rst),
        .commit     (commit),
        .frame_bits (frame_bits),
        .mask       (mask_q)
    );

    for (genvar k = 0; k < NUM_OUT; k++) begin : g_gate
        fz_gate_cell cell_i (
            .clk_in   (out_clk[k]),
            .rst      (rst),
            .en_async (mask_q[k]),
            .clk_out  (gated_clk[k])
        );
    end

    // R5
    commit_load_chk: assert property (@(posedge sclk) disable iff (rst)
        commit |=> (mask_q == $past(frame_bits)));
endmodule

// File: tb/clk_freeze_ctl_tb_top.sv
`timescale 1ns/1ps
module clk_freeze_ctl_tb_top;
    localparam int N = 12;
    localparam logic [N-1:0] VECS [8] = '{
        12'h000, 12'hFFF, 12'h555, 12'hAAA,
        12'h001, 12'h800, 12'hF0F, 12'h0F0
    };

    logic         sclk = 1'b0;
    logic         rst  = 1'b1;
    logic         sdin = 1'b1;
    logic         ca = 1'b0, cb = 1'b0, cc = 1'b0;
    logic [N-1:0] out_clk;
    logic [N-1:0] gated_clk;
    logic [N-1:0] mask_q;

    int errors = 0;
    int checks = 0;
    int runts  = 0;
    bit mon_on = 1'b0;

    always #4 sclk = ~sclk;
    always #3 ca = ~ca;
    always #5 cb = ~cb;
    always #8 cc = ~cc;
    assign out_clk = {{4{cc}}, {4{cb}}, {4{ca}}};

    clk_freeze_ctl dut_i (
        .sclk      (sclk),
        .rst       (rst),
        .sdin      (sdin),
        .out_clk   (out_clk),
        .gated_clk (gated_clk),
        .mask_q    (mask_q)
    );

    // R8 pulse-width monitor
    for (genvar g = 0; g < N; g++) begin : g_mon
        realtime t_rise = -1.0;
        realtime half   = (g < 4) ? 3.0 : ((g < 8) ? 5.0 : 8.0);
        always @(posedge gated_clk[g]) if (mon_on) t_rise = $realtime;
        always @(negedge gated_clk[g]) begin
            if (mon_on && t_rise >= 0.0 && ($realtime - t_rise) != half) runts++;
        end
    end

    task automatic chk(input bit ok, input string tag,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drives start bit and 12 data bits; returns just after the 12th data edge
    task automatic send_bits(input logic [N-1:0] v);
        @(negedge sclk) sdin = 1'b0;
        for (int i = 0; i < N; i++) begin
            @(negedge sclk) sdin = v[i];
        end
        @(posedge sclk);
        #1;
    endtask

    task automatic go_idle_commit();
        @(negedge sclk) sdin = 1'b1;
        @(posedge sclk);
        #1;
    endtask

    task automatic check_gate(input logic [N-1:0] exp, input string tag);
        int bad = 0;
        logic [N-1:0] snap = '0;
        repeat (16) @(posedge sclk);
        #0.5;
        for (int s = 0; s < 64; s++) begin
            if (gated_clk !== (out_clk & exp)) begin
                bad++;
                snap = gated_clk;
            end
            #1;
        end
        chk(bad == 0, tag, snap, out_clk & exp);
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [N-1:0] prev;
        repeat (6) @(posedge sclk);
        #1;
        // R7 reset state
        chk(mask_q === '1, "R7 mask after reset", mask_q, '1);
        @(negedge sclk) rst = 1'b0;
        mon_on = 1'b1;
        check_gate('1, "R7 all outputs enabled after reset");

        // R1 idle line
        repeat (30) @(posedge sclk);
        #1;
        chk(mask_q === '1, "R1 idle high keeps mask", mask_q, '1);

        // table walk: R2 R3 R4 R5
        prev = '1;
        for (int t = 0; t < 8; t++) begin
            send_bits(VECS[t]);
            chk(mask_q === prev, "R5 mask held through 12th bit edge", mask_q, prev);
            go_idle_commit();
            chk(mask_q === VECS[t], "R3 R2 mask after frame", mask_q, VECS[t]);
            check_gate(VECS[t], "R4 R3 gating follows mask");
            prev = VECS[t];
        end

        // R1 long idle after a mixed mask
        send_bits(12'h5A5);
        go_idle_commit();
        repeat (40) @(posedge sclk);
        #1;
        chk(mask_q === 12'h5A5, "R1 mask stable over idle", mask_q, 12'h5A5);
        check_gate(12'h5A5, "R1 outputs stable over idle");

        // R6 back-to-back frames
        send_bits(12'h3C3);
        send_bits(12'hC3C);
        chk(mask_q === 12'h3C3, "R6 first of back-to-back committed", mask_q, 12'h3C3);
        go_idle_commit();
        chk(mask_q === 12'hC3C, "R6 second of back-to-back committed", mask_q, 12'hC3C);
        check_gate(12'hC3C, "R6 gating after back-to-back");

        // R7 reset mid-frame
        @(negedge sclk) sdin = 1'b0;
        for (int i = 0; i < 5; i++) @(negedge sclk) sdin = 1'b0;
        rst = 1'b1;
        sdin = 1'b1;
        repeat (4) @(posedge sclk);
        #1;
        chk(mask_q === '1, "R7 reset during frame", mask_q, '1);
        @(negedge sclk) rst = 1'b0;
        check_gate('1, "R7 outputs enabled after mid-frame reset");
        repeat (10) @(posedge sclk);
        #1;
        chk(mask_q === '1, "R7 abandoned frame not resumed", mask_q, '1);

        // R8 runt monitor result
        chk(runts == 0, "R8 no runt pulses", N'(runts), '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule